// File: doc/BRIEF.md
# Mailbox Word FIFO with Watermark Events

This block carries 32-bit words from a sending agent to a receiving agent through a 32-entry first-in first-out store. Both agents reach it through one word-wide register port. The sender writes words into a push register, and the receiver takes them out through a pop register. Other registers give a status word, a programmable watermark, a soft reset and an interrupt cause word. The cause bits are cleared by writing ones to a separate clear register.

Seven interrupt causes are raised by the block:
- entry into full, entry into empty and entry into not-empty;
- the watermark condition rising and the watermark condition falling;
- a push that overflows and a pop that underflows.

Each agent has its own enable mask over the causes and its own interrupt line. A sender usually unmasks empty and overflow, so it learns when the receiver has drained the queue. A receiver usually unmasks the watermark rise and underflow.

All register offsets are byte addresses on the `bus_addr` input. Only one access happens per cycle, and a write takes priority over a read.

Top module: `mbx_word_fifo`

## Requirements
- R1: A write to offset 0xAC appends `bus_wdata` to the queue. A read of offset 0xB0 removes the oldest word and returns it on `bus_rdata` in the cycle after the read strobe. Words leave in the order they entered.
- R2: A read of offset 0xB4 returns the status word, with all other bits zero. The bits are: bit 0 is high when occupancy is at least the watermark, bit 1 is full (32 words), bit 2 is empty, bit 3 is the underflow flag and bit 4 is the overflow flag. After reset the status word reads 0x4.
- R3: A push while the queue is full is discarded and leaves the contents unchanged. It sets the overflow flag and interrupt cause bit 6.
- R4: A pop while the queue is empty returns zero and removes nothing. It sets the underflow flag and interrupt cause bit 7. Both sticky flags stay set until a soft reset.
- R5: Offset 0xB8 holds a 6-bit watermark that resets to 32 and reads back as written. Cause bit 4 is set when the watermark condition turns true, and cause bit 5 when it turns false.
- R6: The cause word at offset 0xC8 latches a condition event one cycle after the occupancy change that causes it. Entering full sets bit 2, entering empty sets bit 3 and leaving empty sets bit 8. No cause is set out of reset.
- R7: Writing a one to bit k of offset 0xC4 clears cause bit k. If an event for bit k arrives in the same cycle, the event wins.
- R8: A write to offset 0xCC with bit 0 high empties the queue and clears both sticky flags. It keeps the watermark and the cause word. A write there with bit 0 low has no effect.
- R9: Offsets 0xBC and 0xC0 hold the enable masks for `irq_tx` and `irq_rx`. Only bits 2 to 8 are kept, and the rest read as zero. Each line is high in the cycle after any cause bit is set under its mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Byte offset of the access |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe, ignored when `bus_wr` is high |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid one cycle after the read strobe |
| irq_tx | output | 1 | Sender-side interrupt |
| irq_rx | output | 1 | Receiver-side interrupt |

## Verification
The bench builds the block with its default parameters: a 32-bit word and a 32-entry queue. With these values the queue fills in a few dozen cycles, so the full and overflow paths are reached quickly. The 6-bit pointers also wrap many times during a run of mixed traffic. Watermarks of 0, 3 and 32 exercise the watermark condition when it is always true, when it crosses low in the queue and when it crosses at full depth. Clears written in the same cycle as a new event cover the case where the event must win.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  localparam logic [7:0] OFS_PUSH  = 8'hAC;
  localparam logic [7:0] OFS_POP   = 8'hB0;
  localparam logic [7:0] OFS_STAT  = 8'hB4;
  localparam logic [7:0] OFS_WMARK = 8'hB8;
  localparam logic [7:0] OFS_EN_TX = 8'hBC;
  localparam logic [7:0] OFS_EN_RX = 8'hC0;
  localparam logic [7:0] OFS_ICLR  = 8'hC4;
  localparam logic [7:0] OFS_ISTAT = 8'hC8;
  localparam logic [7:0] OFS_SRST  = 8'hCC;

  localparam int EV_W      = 9;
  localparam int EV_FULL   = 2;
  localparam int EV_EMPTY  = 3;
  localparam int EV_WM_UP  = 4;
  localparam int EV_WM_DN  = 5;
  localparam int EV_OFLOW  = 6;
  localparam int EV_UFLOW  = 7;
  localparam int EV_NEMPTY = 8;
  localparam logic [EV_W-1:0] EV_KEEP = 9'h1FC;

  typedef struct packed {
    logic oflow;
    logic uflow;
    logic empty;
    logic full;
    logic wm;
  } fifo_stat_t;
endpackage

// File: rtl/mbx_fifo_store.sv
module mbx_fifo_store #(
  parameter int DW = 32,
  parameter int AW = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clear,
  input  logic          push,
  input  logic          pop,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic [AW:0]   count,
  output logic          full,
  output logic          empty
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];
  logic [AW:0]   wptr, rptr;
  logic [DW-1:0] rd_q;

  assign count = wptr - rptr;
  assign empty = (wptr == rptr);
  assign full  = (wptr[AW] != rptr[AW]) && (wptr[AW-1:0] == rptr[AW-1:0]);
  assign rdata = rd_q;

  always_ff @(posedge clk) begin
    if (push && !full) mem[wptr[AW-1:0]] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (pop && !empty) rd_q <= mem[rptr[AW-1:0]];
  end

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      wptr <= '0;
      rptr <= '0;
    end else begin
      if (push && !full) wptr <= wptr + 1'b1;
      if (pop && !empty) rptr <= rptr + 1'b1;
    end
  end
endmodule

// File: rtl/mbx_event_gen.sv
module mbx_event_gen
  import mbx_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            cond_full,
  input  logic            cond_empty,
  input  logic            cond_wm,
  input  logic            oflow_ev,
  input  logic            uflow_ev,
  input  logic            clr_we,
  input  logic [EV_W-1:0] clr_bits,
  input  logic [EV_W-1:0] en_a,
  input  logic [EV_W-1:0] en_b,
  output logic [EV_W-1:0] istat,
  output logic            irq_a,
  output logic            irq_b
);
  logic            prev_full, prev_empty, prev_wm;
  logic [EV_W-1:0] istat_q, ev, clr_mask;
  logic [EV_W-1:0] en [2];
  logic [1:0]      irq_vec;

  always_comb begin
    ev            = '0;
    ev[EV_FULL]   = cond_full && !prev_full;
    ev[EV_EMPTY]  = cond_empty && !prev_empty;
    ev[EV_NEMPTY] = !cond_empty && prev_empty;
    ev[EV_WM_UP]  = cond_wm && !prev_wm;
    ev[EV_WM_DN]  = !cond_wm && prev_wm;
    ev[EV_OFLOW]  = oflow_ev;
    ev[EV_UFLOW]  = uflow_ev;
  end

  assign clr_mask = clr_we ? clr_bits : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_full  <= 1'b0;
      prev_empty <= 1'b1;
      prev_wm    <= 1'b0;
      istat_q    <= '0;
    end else begin
      prev_full  <= cond_full;
      prev_empty <= cond_empty;
      prev_wm    <= cond_wm;
      istat_q    <= (istat_q & ~clr_mask) | ev;
    end
  end

  assign en[0] = en_a;
  assign en[1] = en_b;

  for (genvar s = 0; s < 2; s++) begin : g_side
    logic irq_r;
    always_ff @(posedge clk) begin
      if (rst) irq_r <= 1'b0;
      else     irq_r <= |(istat_q & en[s]);
    end
    assign irq_vec[s] = irq_r;
  end

  assign istat = istat_q;
  assign irq_a = irq_vec[0];
  assign irq_b = irq_vec[1];
endmodule

// File: rtl/mbx_word_fifo.sv
module mbx_word_fifo
  import mbx_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int DEPTH_LOG2 = 5,
  parameter int ADDR_W     = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq_tx,
  output logic              irq_rx
);
  localparam int DEPTH = 1 << DEPTH_LOG2;
  localparam int WM_W  = DEPTH_LOG2 + 1;

  logic              rd_only;
  logic              push_req, pop_req, srst_req;
  logic              wr_wmark, wr_en_tx, wr_en_rx, wr_iclr;
  logic              full, empty, cond_wm;
  logic              oflow_ev, uflow_ev;
  logic              oflow_q, uflow_q;
  logic [WM_W-1:0]   occ, wmark_q;
  logic [EV_W-1:0]   en_tx_q, en_rx_q, istat;
  logic [DATA_W-1:0] ram_q, rd_mux, reg_q;
  logic              pop_sel_q, zero_q;
  fifo_stat_t        stat;

  assign rd_only  = bus_rd && !bus_wr;
  assign push_req = bus_wr && (bus_addr == ADDR_W'(OFS_PUSH));
  assign pop_req  = rd_only && (bus_addr == ADDR_W'(OFS_POP));
  assign srst_req = bus_wr && (bus_addr == ADDR_W'(OFS_SRST)) && bus_wdata[0];
  assign wr_wmark = bus_wr && (bus_addr == ADDR_W'(OFS_WMARK));
  assign wr_en_tx = bus_wr && (bus_addr == ADDR_W'(OFS_EN_TX));
  assign wr_en_rx = bus_wr && (bus_addr == ADDR_W'(OFS_EN_RX));
  assign wr_iclr  = bus_wr && (bus_addr == ADDR_W'(OFS_ICLR));

  assign oflow_ev = push_req && full;
  assign uflow_ev = pop_req && empty;

  mbx_fifo_store #(.DW(DATA_W), .AW(DEPTH_LOG2)) u_store (
    .clk   (clk),
    .rst   (rst),
    .clear (srst_req),
    .push  (push_req),
    .pop   (pop_req),
    .wdata (bus_wdata),
    .rdata (ram_q),
    .count (occ),
    .full  (full),
    .empty (empty)
  );

  assign cond_wm = (occ >= wmark_q);

  mbx_event_gen u_events (
    .clk        (clk),
    .rst        (rst),
    .cond_full  (full),
    .cond_empty (empty),
    .cond_wm    (cond_wm),
    .oflow_ev   (oflow_ev),
    .uflow_ev   (uflow_ev),
    .clr_we     (wr_iclr),
    .clr_bits   (bus_wdata[EV_W-1:0]),
    .en_a       (en_tx_q),
    .en_b       (en_rx_q),
    .istat      (istat),
    .irq_a      (irq_tx),
    .irq_b      (irq_rx)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      wmark_q <= WM_W'(DEPTH);
      en_tx_q <= '0;
      en_rx_q <= '0;
      oflow_q <= 1'b0;
      uflow_q <= 1'b0;
    end else begin
      if (wr_wmark) wmark_q <= bus_wdata[WM_W-1:0];
      if (wr_en_tx) en_tx_q <= bus_wdata[EV_W-1:0] & EV_KEEP;
      if (wr_en_rx) en_rx_q <= bus_wdata[EV_W-1:0] & EV_KEEP;
      if (srst_req) begin
        oflow_q <= 1'b0;
        uflow_q <= 1'b0;
      end else begin
        if (oflow_ev) oflow_q <= 1'b1;
        if (uflow_ev) uflow_q <= 1'b1;
      end
    end
  end

  assign stat = '{oflow: oflow_q, uflow: uflow_q, empty: empty, full: full, wm: cond_wm};

  always_comb begin
    rd_mux = '0;
    case (bus_addr)
      ADDR_W'(OFS_STAT):  rd_mux[$bits(fifo_stat_t)-1:0] = stat;
      ADDR_W'(OFS_WMARK): rd_mux[WM_W-1:0] = wmark_q;
      ADDR_W'(OFS_EN_TX): rd_mux[EV_W-1:0] = en_tx_q;
      ADDR_W'(OFS_EN_RX): rd_mux[EV_W-1:0] = en_rx_q;
      ADDR_W'(OFS_ISTAT): rd_mux[EV_W-1:0] = istat;
      default:            rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_q     <= '0;
      pop_sel_q <= 1'b0;
      zero_q    <= 1'b0;
    end else begin
      pop_sel_q <= pop_req;
      zero_q    <= uflow_ev;
      if (rd_only) reg_q <= rd_mux;
    end
  end

  assign bus_rdata = pop_sel_q ? (zero_q ? '0 : ram_q) : reg_q;
endmodule

// File: rtl/mbx_word_fifo_chk.sv
module mbx_word_fifo_chk #(
  parameter int DEPTH_LOG2 = 5
) (
  input logic                clk,
  input logic                rst,
  input logic                push_req,
  input logic                pop_req,
  input logic                srst_req,
  input logic                full,
  input logic                empty,
  input logic [DEPTH_LOG2:0] occ,
  input logic                oflow_q,
  input logic                uflow_q
);
  localparam int DEPTH = 1 << DEPTH_LOG2;

  // R1: an accepted push grows occupancy by one
  a_r1_push_grows: assert property (@(posedge clk) disable iff (rst)
    (push_req && !full && !srst_req) |=> (occ == $past(occ) + 1'b1));

  // R2: full and empty never coincide, occupancy bounded by depth
  a_r2_flags_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(full && empty) && (occ <= (DEPTH_LOG2+1)'(DEPTH)));

  // R3: push into a full queue changes nothing but the flag
  a_r3_no_overflow: assert property (@(posedge clk) disable iff (rst)
    (push_req && full) |=> ((occ == $past(occ)) && oflow_q));

  // R4: pop from empty leaves it empty with the flag raised
  a_r4_empty_pop: assert property (@(posedge clk) disable iff (rst)
    (pop_req && empty) |=> (empty && uflow_q));

  // R4: underflow flag is sticky
  a_r4_uflow_sticky: assert property (@(posedge clk) disable iff (rst)
    (uflow_q && !srst_req) |=> uflow_q);

  // R8: soft reset empties and clears flags
  a_r8_soft_reset: assert property (@(posedge clk) disable iff (rst)
    srst_req |=> (empty && !oflow_q && !uflow_q));
endmodule

bind mbx_word_fifo mbx_word_fifo_chk #(.DEPTH_LOG2(DEPTH_LOG2)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .push_req (push_req),
  .pop_req  (pop_req),
  .srst_req (srst_req),
  .full     (full),
  .empty    (empty),
  .occ      (occ),
  .oflow_q  (oflow_q),
  .uflow_q  (uflow_q)
);

// File: tb/mbx_word_fifo_test.sv
`timescale 1ns/1ps
module mbx_word_fifo_test;
  import mbx_pkg::*;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_tx, irq_rx;

  always #4 clk = ~clk;

  mbx_word_fifo uut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_tx(irq_tx), .irq_rx(irq_rx)
  );

  int    n_cmp = 0;
  int    n_bad = 0;
  string phase_tag = "R2";
  bit    done = 0;

  // reference model state
  logic [31:0] q[$];
  int          m_wm;
  bit [8:0]    m_ena, m_enb, m_ist;
  bit          m_ofl, m_ufl, m_pf, m_pe, m_pw, m_ia, m_ib, m_valid;
  logic [31:0] m_exp;
  string       m_tag;

  always @(posedge clk) begin : ref_model
    int       sz;
    bit       cf, ce, cw;
    bit [8:0] ev, clrm;
    if (rst) begin
      q.delete();
      m_wm = 32; m_ena = '0; m_enb = '0; m_ist = '0;
      m_ofl = 0; m_ufl = 0; m_pf = 0; m_pe = 1; m_pw = 0;
      m_ia = 0; m_ib = 0; m_valid = 0; m_exp = '0; m_tag = "R2";
    end else begin
      sz = q.size();
      cf = (sz == 32); ce = (sz == 0); cw = (sz >= m_wm);
      ev = '0;
      ev[2] = cf && !m_pf;
      ev[3] = ce && !m_pe;
      ev[8] = !ce && m_pe;
      ev[4] = cw && !m_pw;
      ev[5] = !cw && m_pw;
      clrm = '0;
      m_valid = 0;
      m_ia = |(m_ist & m_ena);
      m_ib = |(m_ist & m_enb);
      if (bus_wr) begin
        case (bus_addr)
          OFS_PUSH:  if (cf) begin ev[6] = 1; m_ofl = 1; end else q.push_back(bus_wdata);
          OFS_SRST:  if (bus_wdata[0]) begin q.delete(); m_ofl = 0; m_ufl = 0; end
          OFS_WMARK: m_wm = int'(bus_wdata[5:0]);
          OFS_EN_TX: m_ena = bus_wdata[8:0] & 9'h1FC;
          OFS_EN_RX: m_enb = bus_wdata[8:0] & 9'h1FC;
          OFS_ICLR:  clrm = bus_wdata[8:0];
          default: ;
        endcase
      end else if (bus_rd) begin
        m_valid = 1;
        case (bus_addr)
          OFS_POP:   if (ce) begin ev[7] = 1; m_ufl = 1; m_exp = '0; end
                     else m_exp = q.pop_front();
          OFS_STAT:  m_exp = {27'd0, m_ofl, m_ufl, ce, cf, cw};
          OFS_WMARK: m_exp = 32'(m_wm);
          OFS_EN_TX: m_exp = {23'd0, m_ena};
          OFS_EN_RX: m_exp = {23'd0, m_enb};
          OFS_ISTAT: m_exp = {23'd0, m_ist};
          default:   m_exp = '0;
        endcase
      end
      m_ist = (m_ist & ~clrm) | ev;
      m_pf = cf; m_pe = ce; m_pw = cw;
      m_tag = phase_tag;
    end
  end

  // compare every clock, away from the active edge
  always @(negedge clk) begin
    if (!rst && !done) begin
      n_cmp++;
      if (irq_tx !== m_ia) begin
        n_bad++;
        $display("FAIL %s/R9 irq_tx got %0b exp %0b at %0t", m_tag, irq_tx, m_ia, $time);
      end
      n_cmp++;
      if (irq_rx !== m_ib) begin
        n_bad++;
        $display("FAIL %s/R9 irq_rx got %0b exp %0b at %0t", m_tag, irq_rx, m_ib, $time);
      end
      if (m_valid) begin
        n_cmp++;
        if (bus_rdata !== m_exp) begin
          n_bad++;
          $display("FAIL %s bus_rdata got %h exp %h at %0t", m_tag, bus_rdata, m_exp, $time);
        end
      end
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1; bus_rd = 1'b0;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a);
    bus_addr = a; bus_rd = 1'b1; bus_wr = 1'b0;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run;
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    idle(2);

    // R2 reset values, R5 watermark default, R6 no cause out of reset
    phase_tag = "R2"; rd(OFS_STAT);
    phase_tag = "R5"; rd(OFS_WMARK);
    phase_tag = "R6"; rd(OFS_ISTAT);

    // R9 masks keep only bits 2..8
    phase_tag = "R9";
    wr(OFS_EN_TX, 32'hFFFF_FFFF); rd(OFS_EN_TX);
    wr(OFS_EN_TX, 32'h0000_0048);
    wr(OFS_EN_RX, 32'h0000_0190); rd(OFS_EN_RX);

    // R1 order
    phase_tag = "R1";
    for (int i = 0; i < 5; i++) wr(OFS_PUSH, 32'hA500_0000 + 32'(i));
    rd(OFS_STAT);
    for (int i = 0; i < 5; i++) rd(OFS_POP);
    idle(3);
    phase_tag = "R7"; wr(OFS_ICLR, 32'h1FC); idle(2); rd(OFS_ISTAT);

    // R5 watermark crossings
    phase_tag = "R5";
    wr(OFS_WMARK, 3); rd(OFS_WMARK);
    for (int i = 0; i < 3; i++) wr(OFS_PUSH, 32'h5A00_0000 + 32'(i));
    idle(2); rd(OFS_ISTAT); rd(OFS_STAT);
    rd(OFS_POP); idle(2); rd(OFS_ISTAT);
    wr(OFS_WMARK, 0); idle(2); rd(OFS_STAT); rd(OFS_ISTAT);
    wr(OFS_WMARK, 32);

    // R6 fill to full, R3 overflow
    phase_tag = "R6";
    for (int i = 0; i < 30; i++) wr(OFS_PUSH, 32'hC000_0000 + 32'(i));
    idle(2); rd(OFS_ISTAT); rd(OFS_STAT);
    phase_tag = "R3";
    wr(OFS_PUSH, 32'hDEAD_0001); wr(OFS_PUSH, 32'hDEAD_0002);
    idle(2); rd(OFS_STAT); rd(OFS_ISTAT);
    for (int i = 0; i < 32; i++) rd(OFS_POP);
    phase_tag = "R6"; idle(2); rd(OFS_ISTAT); rd(OFS_STAT);

    // R4 underflow
    phase_tag = "R4";
    rd(OFS_POP); rd(OFS_POP); idle(2); rd(OFS_STAT); rd(OFS_ISTAT);

    // R7 clear and same-cycle event
    phase_tag = "R7";
    wr(OFS_ICLR, 32'h1FC); idle(2); rd(OFS_ISTAT);
    wr(OFS_PUSH, 32'h1234_5678); wr(OFS_ICLR, 32'h100); rd(OFS_ISTAT); rd(OFS_ISTAT);

    // R8 soft reset
    phase_tag = "R8";
    wr(OFS_PUSH, 32'h2); wr(OFS_PUSH, 32'h3);
    wr(OFS_SRST, 32'h0); rd(OFS_STAT); rd(OFS_POP);
    wr(OFS_SRST, 32'h1); rd(OFS_STAT); rd(OFS_ISTAT); rd(OFS_WMARK);
    rd(OFS_POP); idle(2); rd(OFS_STAT);

    // mixed traffic
    phase_tag = "R1";
    for (int i = 0; i < 3000; i++) begin
      int r;
      r = $urandom_range(0, 19);
      if (r < 8)       wr(OFS_PUSH, $urandom);
      else if (r < 14) rd(OFS_POP);
      else if (r == 14) rd(OFS_STAT);
      else if (r == 15) rd(OFS_ISTAT);
      else if (r == 16) wr(OFS_ICLR, $urandom);
      else if (r == 17) wr(OFS_WMARK, $urandom_range(0, 33));
      else if (r == 18 && $urandom_range(0, 9) == 0) wr(OFS_SRST, 1);
      else idle(1);
    end
    idle(4);
    finish_run();
  end
endmodule